// File: doc/BRIEF.md
# 32-bit memory operand address generator

This block forms the memory operand address of an instruction that uses 32-bit addressing. A start pulse delivers the two-bit addressing mode (`mod`) and the three-bit register/memory code (`rm`) of the instruction's addressing byte. The block then pulls the bytes that follow from a valid/ready byte stream. It takes an optional scale-index-base byte first, then an optional 8-bit or 32-bit displacement. From these it builds the 32-bit offset and adds the offset to a segment base, which gives the linear address.

It reads the eight 32-bit general registers from a flat input bus. It picks the data segment base or the stack segment base from the base register that is in use. An active segment-override flag replaces that choice with a caller-supplied base. The register-direct mode (`mod`=3), 16-bit addressing, prefix decoding and fault checks sit outside this block.

The register, segment-base and override inputs are sampled in the cycle after the last needed byte is taken. The caller holds them valid until `done_o` rises.

Top module: `ea32_gen`

## Requirements
- R1: Register codes index `gpr_i` as slices `[32*i +: 32]`, with i = 0 EAX, 1 ECX, 2 EDX, 3 EBX, 4 ESP, 5 EBP, 6 ESI, 7 EDI. For `rm` in {0,1,2,3,6,7} the offset is register `rm` plus the displacement, and the segment is DS. The displacement is 0 for `mod`=0, a sign-extended byte for `mod`=1, and a 32-bit value for `mod`=2.
- R2: `rm`=5 with `mod`=0 uses no base register. The offset is a 32-bit displacement, and the segment is DS.
- R3: `rm`=5 with `mod`=1 or 2 uses EBP plus the displacement, and the segment is SS.
- R4: `rm`=4 means a scale-index-base byte follows, and it is consumed before any displacement. Its bits [2:0] name the base, bits [5:3] name the index, and bits [7:6] give a left shift of 0..3 applied to the index before it is added.
- R5: An index code of 4 adds zero.
- R6: A base code of 4 selects ESP with SS. A base code of 5 with `mod`=0 selects no base plus a 32-bit displacement with DS. A base code of 5 with a nonzero `mod` selects EBP with SS, and the displacement given by `mod` is still added.
- R7: When `seg_ovr_i` is high, `seg_ovr_base_i` replaces the default segment base. The offset does not change.
- R8: Displacement bytes arrive least significant first. All sums wrap modulo 2^32.
- R9: `byte_ready_o` is high only while a needed byte is still outstanding, so exactly the needed number of bytes is consumed. It is low in any cycle where `start_i` is high, and a start in any state abandons the operation in progress.
- R10: `done_o` is high for one cycle, the second cycle after the final byte is taken (or after the start cycle when no byte is needed). `offset_o` and `lin_addr_o` update only at that point and hold their values until the next completion.
- R11: While reset is asserted and right after it, `done_o` and `byte_ready_o` are 0, and `offset_o` and `lin_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new address computation |
| mod_i | input | 2 | Addressing mode field, sampled with start |
| rm_i | input | 3 | Register/memory code, sampled with start |
| gpr_i | input | 256 | Eight general registers, 32 bits each |
| ds_base_i | input | 32 | Data segment base |
| ss_base_i | input | 32 | Stack segment base |
| seg_ovr_i | input | 1 | Segment override active |
| seg_ovr_base_i | input | 32 | Base used when the override is active |
| byte_valid_i | input | 1 | Stream byte present |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Block takes the stream byte this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| offset_o | output | 32 | Computed offset |
| lin_addr_o | output | 32 | Segment base plus offset |

## Verification
Two events can land in the same cycle. One is the completion pulse of one operation and the start of the next. The other is a new start and a stream byte that is on offer during a byte fetch. Nearly every operation in the sweep is started in the very cycle that `done_o` of the previous one is high. Each completion is judged on its exact cycle and on its values, so a lost or merged pulse shows up. In a directed case, a start is raised while a byte is valid in the middle of a displacement fetch. `byte_ready_o` must be low in that cycle, and the restarted operation must produce its own correct address.

// File: rtl/ea32_pkg.sv
package ea32_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SIB  = 2'd1,
    ST_DISP = 2'd2,
    ST_FIN  = 2'd3
  } ea_state_e;

  typedef enum logic [1:0] {
    DK_NONE  = 2'd0,
    DK_SHORT = 2'd1,
    DK_LONG  = 2'd2
  } disp_kind_e;

  localparam logic [2:0] RM_SIB   = 3'd4;
  localparam logic [2:0] REG_SP   = 3'd4;
  localparam logic [2:0] REG_BP   = 3'd5;
  localparam logic [2:0] IDX_NONE = 3'd4;

  // Displacement size from the mode field; base5 flags a base code of 5
  function automatic disp_kind_e disp_kind(input logic [1:0] m, input logic base5);
    disp_kind_e k;
    case (m)
      2'd1:    k = DK_SHORT;
      2'd2:    k = DK_LONG;
      2'd0:    k = base5 ? DK_LONG : DK_NONE;
      default: k = DK_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/ea32_ctrl.sv
module ea32_ctrl
  import ea32_pkg::*;
#(
  parameter int unsigned DISP_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] mod_i,
  input  logic [2:0] rm_i,
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output logic       ready_o,
  output logic       disp_load_o,
  output logic       fin_o,
  output logic [1:0] mod_o,
  output logic [2:0] rm_o,
  output logic [7:0] sib_o,
  output logic       short_o
);

  localparam int unsigned CW = (DISP_BYTES > 1) ? $clog2(DISP_BYTES) : 1;
  localparam logic [CW-1:0] CNT_LONG = CW'(DISP_BYTES - 1);

  ea_state_e   st_q, st_d;
  logic [1:0]  mod_q, mod_d;
  logic [2:0]  rm_q, rm_d;
  logic [7:0]  sib_q, sib_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        short_q, short_d;
  logic        beat;
  disp_kind_e  dk;

  assign ready_o     = ((st_q == ST_SIB) || (st_q == ST_DISP)) && !start_i;
  assign beat        = valid_i && ready_o;
  assign disp_load_o = beat && (st_q == ST_DISP);
  assign fin_o       = (st_q == ST_FIN);
  assign mod_o       = mod_q;
  assign rm_o        = rm_q;
  assign sib_o       = sib_q;
  assign short_o     = short_q;

  always_comb begin
    st_d    = st_q;
    mod_d   = mod_q;
    rm_d    = rm_q;
    sib_d   = sib_q;
    cnt_d   = cnt_q;
    short_d = short_q;
    dk      = DK_NONE;
    if (start_i) begin
      mod_d   = mod_i;
      rm_d    = rm_i;
      sib_d   = '0;
      short_d = (mod_i == 2'd1);
      cnt_d   = '0;
      dk      = disp_kind(mod_i, rm_i == REG_BP);
      if (rm_i == RM_SIB) begin
        st_d = ST_SIB;
      end else if (dk != DK_NONE) begin
        st_d  = ST_DISP;
        cnt_d = (dk == DK_LONG) ? CNT_LONG : '0;
      end else begin
        st_d = ST_FIN;
      end
    end else begin
      case (st_q)
        ST_SIB: begin
          if (beat) begin
            sib_d = byte_i;
            dk    = disp_kind(mod_q, byte_i[2:0] == REG_BP);
            if (dk != DK_NONE) begin
              st_d  = ST_DISP;
              cnt_d = (dk == DK_LONG) ? CNT_LONG : '0;
            end else begin
              st_d = ST_FIN;
            end
          end
        end
        ST_DISP: begin
          if (beat) begin
            if (cnt_q == '0) st_d = ST_FIN;
            else             cnt_d = cnt_q - CW'(1);
          end
        end
        ST_FIN:  st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mod_q   <= '0;
      rm_q    <= '0;
      sib_q   <= '0;
      cnt_q   <= '0;
      short_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      mod_q   <= mod_d;
      rm_q    <= rm_d;
      sib_q   <= sib_d;
      cnt_q   <= cnt_d;
      short_q <= short_d;
    end
  end

  // R6: base code 5 under mode 0 must go on to fetch a 32-bit displacement
  p_sib_disp32_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SIB && beat && mod_q == 2'd0 && byte_i[2:0] == REG_BP) |=> (st_q == ST_DISP));

  // R9: a byte is taken only when the stream offers one
  p_beat_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_load_o |-> valid_i);

  // R10: the final state lasts exactly one cycle unless a new start arrives
  p_fin_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && !start_i) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/ea32_disp.sv
module ea32_disp #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [7:0]   byte_i,
  input  logic         short_i,
  output logic [W-1:0] disp_o
);

  logic [W-1:0] d_q, d_d;

  // Bytes enter at the top and shift down: least significant byte first
  always_comb begin
    d_d = d_q;
    if (clr_i)       d_d = '0;
    else if (load_i) d_d = {byte_i, d_q[W-1:8]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_q <= '0;
    else        d_q <= d_d;
  end

  assign disp_o = short_i ? {{(W-8){d_q[W-1]}}, d_q[W-1 -: 8]} : d_q;

  // R8: a new operation starts from an empty displacement
  p_disp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (d_q == '0));

endmodule

// File: rtl/ea32_addr.sv
module ea32_addr
  import ea32_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned NREG = 8
) (
  input  logic [NREG*W-1:0] gpr_i,
  input  logic [1:0]        mod_i,
  input  logic [2:0]        rm_i,
  input  logic [7:0]        sib_i,
  input  logic [W-1:0]      disp_i,
  input  logic [W-1:0]      ds_base_i,
  input  logic [W-1:0]      ss_base_i,
  input  logic              ovr_i,
  input  logic [W-1:0]      ovr_base_i,
  output logic [W-1:0]      off_o,
  output logic [W-1:0]      lin_o
);

  logic [2:0]   base_code;
  logic         use_base;
  logic         use_ss;
  logic [W-1:0] base_val;
  logic [W-1:0] idx_val;
  logic [W-1:0] seg_val;

  always_comb begin
    base_code = rm_i;
    idx_val   = '0;
    if (rm_i == RM_SIB) begin
      base_code = sib_i[2:0];
      if (sib_i[5:3] != IDX_NONE)
        idx_val = gpr_i[W*int'(sib_i[5:3]) +: W] << sib_i[7:6];
    end
    use_base = !((base_code == REG_BP) && (mod_i == 2'd0));
    use_ss   = use_base && ((base_code == REG_BP) || (base_code == REG_SP));
    base_val = use_base ? gpr_i[W*int'(base_code) +: W] : '0;
    off_o    = base_val + idx_val + disp_i;
    if (ovr_i)       seg_val = ovr_base_i;
    else if (use_ss) seg_val = ss_base_i;
    else             seg_val = ds_base_i;
    lin_o = seg_val + off_o;
  end

endmodule

// File: rtl/ea32_gen.sv
module ea32_gen #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [1:0]     mod_i,
  input  logic [2:0]     rm_i,
  input  logic [8*W-1:0] gpr_i,
  input  logic [W-1:0]   ds_base_i,
  input  logic [W-1:0]   ss_base_i,
  input  logic           seg_ovr_i,
  input  logic [W-1:0]   seg_ovr_base_i,
  input  logic           byte_valid_i,
  input  logic [7:0]     byte_data_i,
  output logic           byte_ready_o,
  output logic           done_o,
  output logic [W-1:0]   offset_o,
  output logic [W-1:0]   lin_addr_o
);

  localparam int unsigned NREG       = 8;
  localparam int unsigned DISP_BYTES = W / 8;

  logic         fin, disp_load, short_disp;
  logic [1:0]   mod_q;
  logic [2:0]   rm_q;
  logic [7:0]   sib_q;
  logic [W-1:0] disp_val, off_c, lin_c;
  logic [W-1:0] off_q, off_d, lin_q, lin_d;
  logic         done_q, done_d;

  ea32_ctrl #(.DISP_BYTES(DISP_BYTES)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mod_i       (mod_i),
    .rm_i        (rm_i),
    .valid_i     (byte_valid_i),
    .byte_i      (byte_data_i),
    .ready_o     (byte_ready_o),
    .disp_load_o (disp_load),
    .fin_o       (fin),
    .mod_o       (mod_q),
    .rm_o        (rm_q),
    .sib_o       (sib_q),
    .short_o     (short_disp)
  );

  ea32_disp #(.W(W)) u_disp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i),
    .load_i  (disp_load),
    .byte_i  (byte_data_i),
    .short_i (short_disp),
    .disp_o  (disp_val)
  );

  ea32_addr #(.W(W), .NREG(NREG)) u_addr (
    .gpr_i      (gpr_i),
    .mod_i      (mod_q),
    .rm_i       (rm_q),
    .sib_i      (sib_q),
    .disp_i     (disp_val),
    .ds_base_i  (ds_base_i),
    .ss_base_i  (ss_base_i),
    .ovr_i      (seg_ovr_i),
    .ovr_base_i (seg_ovr_base_i),
    .off_o      (off_c),
    .lin_o      (lin_c)
  );

  always_comb begin
    off_d  = fin ? off_c : off_q;
    lin_d  = fin ? lin_c : lin_q;
    done_d = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      lin_q  <= '0;
      done_q <= 1'b0;
    end else begin
      off_q  <= off_d;
      lin_q  <= lin_d;
      done_q <= done_d;
    end
  end

  assign offset_o   = off_q;
  assign lin_addr_o = lin_q;
  assign done_o     = done_q;

  // R10: completion follows the final state by one cycle
  p_done_after_fin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done_o);

  // R10: the completion pulse is one cycle wide
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: results hold outside the completion update
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(offset_o) && $stable(lin_addr_o)));

endmodule

// File: tb/ea32_gen_bench.sv
module ea32_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  mod;
  logic [2:0]  rm;
  logic [255:0] gpr;
  logic [31:0] ds_b, ss_b, ov_b;
  logic        ov;
  logic        valid;
  logic [7:0]  data;
  logic        ready, done;
  logic [31:0] offset, lin;

  logic [31:0] regs [8];
  logic [31:0] dispv;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) gpr[i*32 +: 32] = regs[i];
  end

  ea32_gen u_ea32_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mod_i(mod), .rm_i(rm),
    .gpr_i(gpr), .ds_base_i(ds_b), .ss_base_i(ss_b), .seg_ovr_i(ov),
    .seg_ovr_base_i(ov_b), .byte_valid_i(valid), .byte_data_i(data),
    .byte_ready_o(ready), .done_o(done), .offset_o(offset), .lin_addr_o(lin)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog R10 got %0d exp %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input int a);
    logic [31:0] v;
    v = 32'(a) * 32'h9E3779B9;
    return v ^ (v >> 13) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic set_vals(input int n);
    for (int i = 0; i < 8; i++) regs[i] = mix(n * 8 + i + 1);
    dispv = mix(n + 777);
    ds_b  = mix(n + 3001);
    ss_b  = mix(n + 5003);
    ov_b  = mix(n + 7007);
    ov    = (n % 3 == 0);
  endtask

  // Starts an operation at the current point, feeds its bytes, checks the result.
  task automatic run_op(input logic [1:0] m, input logic [2:0] r, input logic [7:0] sib, input bit gap);
    logic [31:0] base, idx, dsp, exp_off, exp_lin, seg;
    logic [2:0]  bc;
    logic        ss, nob, shortd, longd;
    logic [7:0]  bq [5];
    int          nb, tmo;
    string       tag;
    // expected values from the requirements
    bc = (r == 3'd4) ? sib[2:0] : r;
    nob = (bc == 3'd5) && (m == 2'd0);
    base = nob ? 32'd0 : regs[bc];
    ss = !nob && (bc == 3'd5 || bc == 3'd4);
    idx = 32'd0;
    if (r == 3'd4 && sib[5:3] != 3'd4) idx = regs[sib[5:3]] << sib[7:6];
    shortd = (m == 2'd1);
    longd  = (m == 2'd2) || nob;
    dsp = shortd ? {{24{dispv[7]}}, dispv[7:0]} : (longd ? dispv : 32'd0);
    exp_off = base + idx + dsp;
    seg = ov ? ov_b : (ss ? ss_b : ds_b);
    exp_lin = seg + exp_off;
    if (r != 3'd4)              tag = (r == 3'd5) ? ((m == 2'd0) ? "R2" : "R3") : "R1";
    else if (sib[5:3] == 3'd4)  tag = "R5";
    else if (bc == 3'd4 || bc == 3'd5) tag = "R6";
    else                        tag = "R4";
    nb = 0;
    if (r == 3'd4) begin bq[0] = sib; nb = 1; end
    if (shortd) begin bq[nb] = dispv[7:0]; nb++; end
    else if (longd) begin
      for (int k = 0; k < 4; k++) bq[nb + k] = dispv[8*k +: 8];
      nb += 4;
    end
    start = 1'b1; mod = m; rm = r;
    #1 check("R9 start-cycle ready", 32'(ready), 32'd0);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < nb; k++) begin
      if (gap && k == 1) begin valid = 1'b0; @(negedge clk); end
      valid = 1'b1; data = bq[k];
      #1;
      tmo = 0;
      while (!ready && tmo < 8) begin @(negedge clk); #1; tmo++; end
      @(negedge clk);
    end
    valid = 1'b0;
    #1 check({"R10 done-early ", tag}, 32'(done), 32'd0);
    @(negedge clk); #1;
    check({"R10 done ", tag}, 32'(done), 32'd1);
    check("R9 ready-after", 32'(ready), 32'd0);
    check({tag, " offset"}, offset, exp_off);
    check(ov ? "R7 linear" : {tag, " linear"}, lin, exp_lin);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; start = 1'b0; mod = '0; rm = '0; valid = 1'b0; data = '0;
    set_vals(1);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 done", 32'(done), 32'd0);
    check("R11 ready", 32'(ready), 32'd0);
    check("R11 offset", offset, 32'd0);
    check("R11 linear", lin, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 done after release", 32'(done), 32'd0);
    @(negedge clk);

    // R8: byte order and modulo-2^32 wrap
    set_vals(11); ov = 1'b0;
    regs[0] = 32'hFFFF_FFF0; dispv = 32'h0000_0020; ds_b = 32'hFFFF_FFFF;
    run_op(2'd2, 3'd0, 8'h00, 1'b0);
    check("R8 wrap offset", offset, 32'h0000_0010);
    check("R8 wrap linear", lin, 32'h0000_000F);
    @(negedge clk);
    set_vals(12); ov = 1'b0; dispv = 32'h1234_5678;
    run_op(2'd0, 3'd5, 8'h00, 1'b1);
    check("R8 byte order", offset, 32'h1234_5678);

    // R10: results hold while inputs change after completion
    set_vals(40);
    repeat (3) @(negedge clk);
    check("R10 hold offset", offset, 32'h1234_5678);
    check("R10 hold done", 32'(done), 32'd0);

    // R9: restart while a displacement byte is on offer
    set_vals(41);
    start = 1'b1; mod = 2'd2; rm = 3'd4;
    @(negedge clk);
    start = 1'b0; valid = 1'b1; data = 8'h01;
    @(negedge clk);
    data = 8'hAA;
    run_op(2'd1, 3'd6, 8'h00, 1'b0);

    // exhaustive sweep, mostly back-to-back with the previous completion
    n = 100;
    for (int m = 0; m < 3; m++) begin
      for (int r = 0; r < 8; r++) begin
        if (r != 4) begin
          set_vals(n);
          if (n % 4 == 1) @(negedge clk);
          run_op(2'(m), 3'(r), 8'h00, n % 5 == 0);
          n++;
        end else begin
          for (int s = 0; s < 256; s++) begin
            set_vals(n);
            if (n % 4 == 1) @(negedge clk);
            run_op(2'(m), 3'd4, 8'(s), n % 5 == 0);
            n++;
          end
        end
      end
    end

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule